// File: doc/BRIEF.md
# Frame-synchronized shadow register updater

This block holds a bank of display configuration registers in two layers. The CPU writes only the front layer, at any time it likes. The display pipeline reads only the working layer. The working layer takes a copy of the whole front layer at a frame boundary, so a change the CPU makes in the middle of a frame never shows up partway down the screen.

The frame boundary comes from one of two vertical sync sources, chosen by a two-bit timing-mode field. In master mode it is the internally generated sync. In TV mode it is an external sync input, which is first brought into the clock domain. The remaining mode codes perform no frame copy. While the display reset control is held high, the working layer tracks the front layer on every cycle, so initial values loaded during setup take effect at once. When drawing is selected, the two start-address registers bypass the frame copy and follow CPU writes directly. A one-cycle pulse marks every frame-start copy.

Top module: `frame_shadow_regs`

## Requirements
- R1: While `rst_n` is low, every working register and `upd_pulse` read 0. The front layer also clears to 0, which the ports show after a later copy.
- R2: With `tmode` = 2'b00, a falling edge of `int_vsync` copies the front layer into the working layer. A falling edge means a high sample followed by a low sample. The copy takes effect at the clock edge that first samples `int_vsync` low, and `upd_pulse` is high in the cycle that follows that edge.
- R3: With `tmode` = 2'b10, a falling edge of `ext_vsync` causes the copy. The copy and `upd_pulse` appear at the third clock edge after the input goes low. In this mode `int_vsync` has no effect.
- R4: With `tmode` = 2'b01 or 2'b11, no sync edge causes a copy, and `upd_pulse` stays 0.
- R5: Between frame copies, and with display reset and drawing both off, CPU writes do not change the working registers.
- R6: While `disp_rst` is 1, each working register takes the value written to its front register at the same clock edge that accepts the write. This holds in every mode.
- R7: While `draw_sel` is 1, working registers 0 and 1 (the start addresses) take a CPU write at the edge that accepts it. All other registers still wait for a frame copy.
- R8: A CPU write accepted at the same edge as a frame copy is included in that copy.
- R9: `upd_pulse` is never high for two cycles in a row.
- R10: A rising edge of the selected sync source causes no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | AW | Register index for the write |
| wr_data | input | DW | Data for the write |
| disp_rst | input | 1 | Display reset; working layer tracks the front layer while high |
| tmode | input | 2 | Timing mode: 00 master, 10 TV, 01 and 11 no frame copy |
| draw_sel | input | 1 | Drawing selected; start addresses update directly |
| int_vsync | input | 1 | Internally generated vertical sync |
| ext_vsync | input | 1 | External vertical sync, asynchronous |
| work_flat | output | NREG*DW | Working registers, register i at bits [i*DW +: DW] |
| upd_pulse | output | 1 | One-cycle marker of a frame-start copy |

## Verification
The bound checker examines every cycle:
- the working layer stays stable when there is no copy, no display reset and no drawing;
- the layers agree while display reset is held;
- the start addresses track their front registers while drawing is selected;
- an internal sync fall in master mode triggers a copy;
- the idle modes never pulse;
- the pulse is one cycle wide.

The following depend on sequences of stimulus, so only the directed scenarios can show them:
- the three-edge latency of the external sync path;
- the fact that the unselected sync source is ignored;
- the inclusion of a write accepted on the copy edge;
- the exact register values after each copy.

// File: rtl/frame_shadow_regs.sv
module frame_shadow_regs #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int SA0  = 0,
  parameter int SA1  = 1,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               disp_rst,
  input  logic [1:0]         tmode,
  input  logic               draw_sel,
  input  logic               int_vsync,
  input  logic               ext_vsync,
  output logic [NREG*DW-1:0] work_flat,
  output logic               upd_pulse
);

  logic [NREG*DW-1:0] front_flat;
  logic int_prev;
  logic ext_s1, ext_s2, ext_s3;
  logic int_fall, ext_fall, frame_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_prev <= 1'b0;
      ext_s1   <= 1'b0;
      ext_s2   <= 1'b0;
      ext_s3   <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      int_prev <= int_vsync;
      ext_s1   <= ext_vsync;
      ext_s2   <= ext_s1;
      ext_s3   <= ext_s2;
      upd_pulse <= frame_trig;
    end
  end

  assign int_fall   = int_prev & ~int_vsync;
  assign ext_fall   = ext_s3 & ~ext_s2;
  assign frame_trig = ((tmode == 2'b00) & int_fall) | ((tmode == 2'b10) & ext_fall);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_SA = (i == SA0) || (i == SA1);
    logic [DW-1:0] front_q, work_q, front_d;
    logic          direct;

    assign front_d = (wr_en && wr_addr == AW'(i)) ? wr_data : front_q;
    assign direct  = IS_SA & draw_sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        front_q <= '0;
        work_q  <= '0;
      end else begin
        front_q <= front_d;
        if (disp_rst || frame_trig || direct)
          work_q <= front_d;
      end
    end

    assign work_flat[i*DW +: DW]  = work_q;
    assign front_flat[i*DW +: DW] = front_q;
  end

endmodule

module frame_shadow_regs_chk #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int SA0  = 0,
  parameter int SA1  = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_rst,
  input logic               draw_sel,
  input logic [1:0]         tmode,
  input logic               int_vsync,
  input logic               upd_pulse,
  input logic [NREG*DW-1:0] work_flat,
  input logic [NREG*DW-1:0] front_flat
);

  AST_RST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    disp_rst |=> (work_flat == front_flat)); // R6

  AST_MASTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode == 2'b00 && $fell(int_vsync)) |=> upd_pulse); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tmode[0] |=> !upd_pulse); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse); // R9

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_rst && !draw_sel) ##1 !upd_pulse |-> $stable(work_flat)); // R5

  AST_DIRECT_SA: assert property (@(posedge clk) disable iff (!rst_n)
    draw_sel |=> (work_flat[SA0*DW +: DW] == front_flat[SA0*DW +: DW] &&
                  work_flat[SA1*DW +: DW] == front_flat[SA1*DW +: DW])); // R7

endmodule

bind frame_shadow_regs frame_shadow_regs_chk #(.NREG(NREG), .DW(DW), .SA0(SA0), .SA1(SA1)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_rst(disp_rst), .draw_sel(draw_sel), .tmode(tmode),
  .int_vsync(int_vsync), .upd_pulse(upd_pulse), .work_flat(work_flat), .front_flat(front_flat)
);

// File: tb/sim_frame_shadow_regs.sv
module sim_frame_shadow_regs;
  localparam int NREG = 8;
  localparam int DW   = 16;

  logic            clk = 0;
  logic            rst_n;
  logic            wr_en;
  logic [2:0]      wr_addr;
  logic [DW-1:0]   wr_data;
  logic            disp_rst;
  logic [1:0]      tmode;
  logic            draw_sel;
  logic            int_vsync;
  logic            ext_vsync;
  logic [NREG*DW-1:0] work_flat;
  logic            upd_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  frame_shadow_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .disp_rst(disp_rst), .tmode(tmode), .draw_sel(draw_sel),
    .int_vsync(int_vsync), .ext_vsync(ext_vsync),
    .work_flat(work_flat), .upd_pulse(upd_pulse)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] wk(int i);
    return work_flat[i*DW +: DW];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write(int a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; disp_rst = 0;
    tmode = 2'b00; draw_sel = 0; int_vsync = 1; ext_vsync = 1;
    cycles(3);
    for (int i = 0; i < NREG; i++) check("R1 work clear", 32'(wk(i)), 0);
    check("R1 pulse clear", 32'(upd_pulse), 0);
    rst_n = 1;
    cycles(3);
    for (int i = 0; i < NREG; i++) check("R1 work after release", 32'(wk(i)), 0);
  endtask

  task automatic t_disp_rst;
    disp_rst = 1;
    for (int i = 0; i < NREG; i++) begin
      write(i, 16'h1000 + 16'(i));
      check("R6 follow write", 32'(wk(i)), 32'(16'h1000 + 16'(i)));
    end
    tmode = 2'b01;
    write(2, 16'h2222);
    check("R6 follow in idle mode", 32'(wk(2)), 32'h2222);
    tmode = 2'b00;
    disp_rst = 0;
  endtask

  task automatic t_hold;
    write(3, 16'hAAAA);
    cycles(4);
    check("R5 hold reg3", 32'(wk(3)), 32'h1003);
    check("R5 no pulse", 32'(upd_pulse), 0);
  endtask

  task automatic t_master;
    @(negedge clk); int_vsync = 0;
    @(negedge clk);
    check("R2 pulse", 32'(upd_pulse), 1);
    check("R2 copy reg3", 32'(wk(3)), 32'hAAAA);
    @(negedge clk);
    check("R9 pulse drops", 32'(upd_pulse), 0);
    write(3, 16'hBBBB);
    int_vsync = 1;
    @(negedge clk);
    check("R10 rise no pulse", 32'(upd_pulse), 0);
    cycles(2);
    check("R10 rise no copy", 32'(wk(3)), 32'hAAAA);
    int_vsync = 0;
    @(negedge clk);
    check("R2 second copy", 32'(wk(3)), 32'hBBBB);
    int_vsync = 1;
    cycles(2);
  endtask

  task automatic t_tv;
    tmode = 2'b10;
    write(4, 16'hCCCC);
    int_vsync = 0;
    cycles(3);
    check("R3 int sync ignored", 32'(wk(4)), 32'h1004);
    int_vsync = 1;
    cycles(2);
    ext_vsync = 0;
    @(negedge clk);
    check("R3 no copy after 1 edge", 32'(upd_pulse), 0);
    @(negedge clk);
    check("R3 no copy after 2 edges", 32'(wk(4)), 32'h1004);
    @(negedge clk);
    check("R3 pulse at edge 3", 32'(upd_pulse), 1);
    check("R3 copy reg4", 32'(wk(4)), 32'hCCCC);
    write(4, 16'hCDCD);
    ext_vsync = 1;
    cycles(5);
    check("R10 ext rise no copy", 32'(wk(4)), 32'hCCCC);
    tmode = 2'b00;
  endtask

  task automatic t_idle(logic [1:0] m, logic [DW-1:0] d);
    tmode = m;
    write(5, d);
    int_vsync = 0; ext_vsync = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R4 no pulse", 32'(upd_pulse), 0);
    end
    check("R4 no copy", 32'(wk(5)), 32'h1005);
    int_vsync = 1; ext_vsync = 1;
    cycles(4);
    tmode = 2'b00;
  endtask

  task automatic t_draw;
    draw_sel = 1;
    write(0, 16'h1234);
    check("R7 start addr 0 direct", 32'(wk(0)), 32'h1234);
    write(1, 16'h5678);
    check("R7 start addr 1 direct", 32'(wk(1)), 32'h5678);
    write(6, 16'h6666);
    check("R7 other reg waits", 32'(wk(6)), 32'h1006);
    @(negedge clk); int_vsync = 0;
    @(negedge clk);
    check("R7 other reg on frame", 32'(wk(6)), 32'h6666);
    int_vsync = 1;
    draw_sel = 0;
    cycles(2);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    int_vsync = 0; wr_en = 1; wr_addr = 3'd7; wr_data = 16'h7777;
    @(negedge clk);
    wr_en = 0;
    check("R8 pulse", 32'(upd_pulse), 1);
    check("R8 same-edge write copied", 32'(wk(7)), 32'h7777);
    check("R8 reg5 copied", 32'(wk(5)), 32'h0505);
    int_vsync = 1;
    cycles(2);
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_disp_rst();
    t_hold();
    t_master();
    t_tv();
    t_idle(2'b01, 16'h0501);
    t_idle(2'b11, 16'h0505);
    t_draw();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule